// File: doc/BRIEF.md
# Parallel Host FIFO Register Interface

This block lets a host processor talk to a peripheral core over an 8-bit asynchronous strobe bus. The bus carries an active-low chip select, one address line, active-low read and write strobes, a data bus split into input, output and output-enable, and an active-low interrupt line. The strobes, chip select, address and write data pass through two-stage synchronizers into the block clock. A host access takes effect when its strobe is released.

Address 0 reaches the data path. A host write queues a byte in a 14-entry transmit queue, which the core drains. A host read returns the oldest byte of a 16-entry receive queue, which the core fills, and the release of the read strobe removes that byte. Address 1 is a status and control byte. It carries a transmit low-water flag, a receive-empty flag, an interrupt mask, a sticky event-interrupt flag and an escape bit.

The interrupt line asserts when the mask is set and either interrupt source is pending. The first source is an event reported by the core on any of five event inputs. The second is the transmit queue dropping to its low-water level.

Top module: `hostbus_fifo_if`

## Requirements
- R1: After reset, the status byte reads 0x60, `int_n` is 1, `tx_valid` is 0 and `esc_out` is 0.
- R2: A write at address 0 with `cs_n` low appends `bus_din` to the transmit queue. The core sees the queue in arrival order on `tx_data`/`tx_valid` and removes the head with `tx_pop`. A write to a queue that already holds 14 bytes is dropped.
- R3: Status bit 6 reads 1 when the transmit queue holds two or fewer bytes, and 0 when it holds three or more.
- R4: A transmit interrupt becomes pending when bit 6 changes from 0 to 1. A status write with bit 6 equal to 0 clears the pending interrupt, and bit 6 still reads its level-based value afterwards.
- R5: Status bit 5 is read-only. It reads 1 when the receive queue is empty and 0 otherwise.
- R6: While the read strobe is low at address 0, `bus_dout` shows the head of the receive queue, and releasing the strobe removes that byte. A read from an empty queue shows 0x00 and changes nothing. `rx_push` stores `rx_data` unless the queue already holds 16 bytes, and `rx_full` flags that state.
- R7: Status bit 4 is a read/write mask. `int_n` is 0 exactly when the mask is 1 and the event interrupt or the transmit interrupt is pending.
- R8: Status bit 3 is read-only. It becomes 1 one cycle after any bit of `evt` is 1, and it stays 1 until `int_clr` is pulsed.
- R9: Status bit 2 is read/write. `esc_out` equals that bit while `esc_en` is 1, and is 0 while `esc_en` is 0.
- R10: Status bits 7, 1 and 0 always read 0, and writing 1 to them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 1 | Register select: 0 = data, 1 = status/control |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_din | input | 8 | Host write data |
| bus_dout | output | 8 | Host read data |
| bus_oe | output | 1 | High while the host reads with the chip selected |
| int_n | output | 1 | Interrupt to the host, active low |
| tx_valid | output | 1 | Transmit queue holds data |
| tx_data | output | 8 | Head of the transmit queue |
| tx_pop | input | 1 | Core removes the transmit head |
| rx_push | input | 1 | Core stores a received byte |
| rx_data | input | 8 | Received byte from the core |
| rx_full | output | 1 | Receive queue holds 16 bytes |
| evt | input | 5 | Core event sources |
| int_clr | input | 1 | Clears the event interrupt |
| esc_en | input | 1 | Enables the escape bit toward the core |
| esc_out | output | 1 | Escape request to the core |

## Verification
A host write or read changes queue or control state on the third clock edge after its strobe is released. The two synchronizer stages account for two edges and the edge-detect register for the third. The bench therefore keeps chip select, address and data steady for four clock cycles after each release, and samples state only after that point. Read data is combinational from the queue head and the status bits, so the bench samples it while the strobe is still low. The core-side effects have fixed delays: `tx_pop`, `rx_push` and `evt` show up one edge later, and the bench checks them at the following falling edge.

// File: rtl/hostbus_fifo_if.sv
module hostbus_fifo_if #(
  parameter int DATA_W      = 8,
  parameter int TX_DEPTH    = 14,
  parameter int RX_DEPTH    = 16,
  parameter int TXE_LEVEL   = 2,
  parameter int N_EVT       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic              int_n,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_pop,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  input  logic [N_EVT-1:0]  evt,
  input  logic              int_clr,
  input  logic              esc_en,
  output logic              esc_out
);

  localparam int TX_PW = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1;
  localparam int RX_PW = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam int TX_CW = $clog2(TX_DEPTH + 1);
  localparam int RX_CW = $clog2(RX_DEPTH + 1);
  localparam int LAST  = SYNC_STAGES - 1;

  // strobe, select, address and data synchronizers
  logic [SYNC_STAGES:0]  rd_sh, wr_sh;
  logic [LAST:0]         cs_sh, a_sh;
  logic [DATA_W-1:0]     d_sh [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sh <= '1;
      wr_sh <= '1;
      cs_sh <= '1;
      a_sh  <= '0;
      for (int i = 0; i < SYNC_STAGES; i++) d_sh[i] <= '0;
    end else begin
      rd_sh <= {rd_sh[SYNC_STAGES-1:0], rd_n};
      wr_sh <= {wr_sh[SYNC_STAGES-1:0], wr_n};
      cs_sh <= {cs_sh, cs_n} >> 0;
      a_sh  <= {a_sh, addr} >> 0;
      d_sh[0] <= bus_din;
      for (int i = 1; i < SYNC_STAGES; i++) d_sh[i] <= d_sh[i-1];
    end
  end

  logic              sel_s, a_s, rd_rise, wr_rise;
  logic [DATA_W-1:0] d_s;
  assign sel_s   = ~cs_sh[LAST];
  assign a_s     = a_sh[LAST];
  assign d_s     = d_sh[LAST];
  assign rd_rise = rd_sh[LAST] & ~rd_sh[SYNC_STAGES];
  assign wr_rise = wr_sh[LAST] & ~wr_sh[SYNC_STAGES];

  logic host_push, host_pop, host_ctl;
  assign host_push = wr_rise & sel_s & ~a_s;
  assign host_ctl  = wr_rise & sel_s &  a_s;
  assign host_pop  = rd_rise & sel_s & ~a_s;

  // transmit queue
  logic [DATA_W-1:0] tx_mem [TX_DEPTH];
  logic [TX_PW-1:0]  tx_wp, tx_rp;
  logic [TX_CW-1:0]  tx_cnt;
  logic              tx_do_push, tx_do_pop;

  assign tx_valid   = (tx_cnt != '0);
  assign tx_data    = tx_mem[tx_rp];
  assign tx_do_push = host_push & (tx_cnt != TX_CW'(TX_DEPTH));
  assign tx_do_pop  = tx_pop & tx_valid;

  always_ff @(posedge clk) begin
    if (tx_do_push) tx_mem[tx_wp] <= d_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_do_push) tx_wp <= (tx_wp == TX_PW'(TX_DEPTH-1)) ? '0 : tx_wp + 1'b1;
      if (tx_do_pop)  tx_rp <= (tx_rp == TX_PW'(TX_DEPTH-1)) ? '0 : tx_rp + 1'b1;
      if (tx_do_push && !tx_do_pop)      tx_cnt <= tx_cnt + 1'b1;
      else if (!tx_do_push && tx_do_pop) tx_cnt <= tx_cnt - 1'b1;
    end
  end

  // receive queue
  logic [DATA_W-1:0] rx_mem [RX_DEPTH];
  logic [RX_PW-1:0]  rx_wp, rx_rp;
  logic [RX_CW-1:0]  rx_cnt;
  logic              rx_do_push, rx_do_pop, rx_empty;

  assign rx_empty   = (rx_cnt == '0);
  assign rx_full    = (rx_cnt == RX_CW'(RX_DEPTH));
  assign rx_do_push = rx_push & ~rx_full;
  assign rx_do_pop  = host_pop & ~rx_empty;

  always_ff @(posedge clk) begin
    if (rx_do_push) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_do_push) rx_wp <= (rx_wp == RX_PW'(RX_DEPTH-1)) ? '0 : rx_wp + 1'b1;
      if (rx_do_pop)  rx_rp <= (rx_rp == RX_PW'(RX_DEPTH-1)) ? '0 : rx_rp + 1'b1;
      if (rx_do_push && !rx_do_pop)      rx_cnt <= rx_cnt + 1'b1;
      else if (!rx_do_push && rx_do_pop) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  // status and control
  logic txe, txe_q, tx_irq, int_stat, intm, esc_bit;
  assign txe = (tx_cnt <= TX_CW'(TXE_LEVEL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe_q    <= 1'b1;
      tx_irq   <= 1'b0;
      int_stat <= 1'b0;
      intm     <= 1'b0;
      esc_bit  <= 1'b0;
    end else begin
      txe_q <= txe;
      if (txe && !txe_q)           tx_irq <= 1'b1;
      else if (host_ctl && !d_s[6]) tx_irq <= 1'b0;
      if (|evt)         int_stat <= 1'b1;
      else if (int_clr) int_stat <= 1'b0;
      if (host_ctl) begin
        intm    <= d_s[4];
        esc_bit <= d_s[2];
      end
    end
  end

  logic [7:0]        status;
  logic [DATA_W-1:0] rx_head;
  assign status   = {1'b0, txe, rx_empty, intm, int_stat, esc_bit, 2'b00};
  assign rx_head  = rx_empty ? '0 : rx_mem[rx_rp];
  assign bus_dout = addr ? DATA_W'(status) : rx_head;
  assign bus_oe   = ~cs_n & ~rd_n;
  assign int_n    = ~(intm & (int_stat | tx_irq));
  assign esc_out  = esc_en & esc_bit;

endmodule

// File: rtl/hostbus_fifo_if_chk.sv
module hostbus_fifo_if_chk #(
  parameter int TX_DEPTH  = 14,
  parameter int RX_DEPTH  = 16,
  parameter int TXE_LEVEL = 2,
  parameter int N_EVT     = 5,
  parameter int TX_CW     = 4,
  parameter int RX_CW     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TX_CW-1:0] tx_cnt,
  input logic [RX_CW-1:0] rx_cnt,
  input logic             rx_push,
  input logic             tx_irq,
  input logic             int_stat,
  input logic             int_clr,
  input logic [N_EVT-1:0] evt,
  input logic             esc_en,
  input logic             esc_out,
  input logic             int_n
);

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= TX_CW'(TX_DEPTH)); // R2

  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= RX_CW'(RX_DEPTH)); // R6

  AST_RX_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0 && !rx_push) |=> rx_cnt == '0); // R6

  AST_TXIRQ_LOW_WATER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_irq) |-> $past(tx_cnt) <= TX_CW'(TXE_LEVEL)); // R4

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> int_stat); // R8

  AST_INT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (int_stat && !int_clr) |=> int_stat); // R8

  AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_stat && !tx_irq) |-> int_n); // R7

  AST_ESC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !esc_en |-> !esc_out); // R9

endmodule

bind hostbus_fifo_if hostbus_fifo_if_chk #(
  .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .TXE_LEVEL(TXE_LEVEL),
  .N_EVT(N_EVT), .TX_CW(TX_CW), .RX_CW(RX_CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rx_push(rx_push),
  .tx_irq(tx_irq), .int_stat(int_stat), .int_clr(int_clr), .evt(evt),
  .esc_en(esc_en), .esc_out(esc_out), .int_n(int_n)
);

// File: tb/hostbus_fifo_if_bench.sv
`timescale 1ns/1ps
module hostbus_fifo_if_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, addr = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] bus_din = '0, rx_data = '0;
  logic [7:0] bus_dout, tx_data;
  logic bus_oe, int_n, tx_valid, rx_full, esc_out;
  logic tx_pop = 1'b0, rx_push = 1'b0, int_clr = 1'b0, esc_en = 1'b1;
  logic [4:0] evt = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  hostbus_fifo_if u_hostbus_fifo_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe), .int_n(int_n),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_data), .rx_full(rx_full),
    .evt(evt), .int_clr(int_clr), .esc_en(esc_en), .esc_out(esc_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; addr = a; bus_din = d;
    @(negedge clk); wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; addr = a;
    @(negedge clk); rd_n = 1'b0;
    repeat (2) @(negedge clk);
    d = bus_dout;
    chk("R6 bus_oe", {7'b0, bus_oe}, 8'h01);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic core_pop;
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic core_push(input logic [7:0] d);
    @(negedge clk); rx_push = 1'b1; rx_data = d;
    @(negedge clk); rx_push = 1'b0;
  endtask

  // {write, addr, data, expected read}
  localparam logic [17:0] VEC [9] = '{
    {1'b1, 1'b1, 8'h14, 8'h00},  // R7 R9: mask and escape set
    {1'b0, 1'b1, 8'h00, 8'h74},  // R7 R9 read back
    {1'b1, 1'b1, 8'h83, 8'h00},  // R10: reserved bits written as 1
    {1'b0, 1'b1, 8'h00, 8'h60},  // R10 read back
    {1'b1, 1'b0, 8'hA1, 8'h00},  // R2
    {1'b1, 1'b0, 8'hB2, 8'h00},  // R2
    {1'b0, 1'b1, 8'h00, 8'h60},  // R3: two queued, flag high
    {1'b1, 1'b0, 8'hC3, 8'h00},  // R2
    {1'b0, 1'b1, 8'h00, 8'h20}   // R3: three queued, flag low
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 int_n", {7'b0, int_n}, 8'h01);
    chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    chk("R1 esc_out", {7'b0, esc_out}, 8'h00);
    bus_read(1'b1, v); chk("R1 status", v, 8'h60);

    for (int i = 0; i < 9; i++) begin
      if (VEC[i][17]) bus_write(VEC[i][16], VEC[i][15:8]);
      else begin
        bus_read(VEC[i][16], v);
        chk($sformatf("vector %0d (R3 R7 R9 R10)", i), v, VEC[i][7:0]);
      end
    end

    // R2 order, R4 transmit interrupt
    chk("R2 head", tx_data, 8'hA1);
    core_pop; chk("R2 second", tx_data, 8'hB2);
    core_pop; chk("R2 third", tx_data, 8'hC3);
    bus_write(1'b1, 8'h50);
    chk("R4 int_n pending", {7'b0, int_n}, 8'h00);
    bus_read(1'b1, v); chk("R4 status", v, 8'h70);
    bus_write(1'b1, 8'h10);
    chk("R4 int_n cleared", {7'b0, int_n}, 8'h01);
    bus_read(1'b1, v); chk("R4 flag unchanged", v, 8'h70);
    core_pop;
    chk("R2 empty", {7'b0, tx_valid}, 8'h00);

    // R2 overflow, R3 at full
    for (int i = 0; i < 15; i++) bus_write(1'b0, 8'h30 + 8'(i));
    bus_read(1'b1, v); chk("R3 full status", v, 8'h30);
    for (int i = 0; i < 14; i++) begin
      chk("R2 drain order", tx_data, 8'h30 + 8'(i));
      core_pop;
    end
    chk("R2 fifteenth dropped", {7'b0, tx_valid}, 8'h00);
    bus_write(1'b1, 8'h10);
    chk("R4 cleared after drain", {7'b0, int_n}, 8'h01);

    // R5 R6 receive path
    core_push(8'h11); core_push(8'h22);
    bus_read(1'b1, v); chk("R5 not empty", v, 8'h50);
    bus_read(1'b0, v); chk("R6 first", v, 8'h11);
    bus_read(1'b0, v); chk("R6 second", v, 8'h22);
    bus_read(1'b0, v); chk("R6 empty read", v, 8'h00);
    bus_read(1'b1, v); chk("R5 empty", v, 8'h70);
    for (int i = 0; i < 17; i++) core_push(8'h40 + 8'(i));
    chk("R6 rx_full", {7'b0, rx_full}, 8'h01);
    for (int i = 0; i < 16; i++) begin
      bus_read(1'b0, v); chk("R6 full drain", v, 8'h40 + 8'(i));
    end
    bus_read(1'b0, v); chk("R6 seventeenth dropped", v, 8'h00);

    // R8 events, R7 mask
    @(negedge clk); evt = 5'b00100;
    @(negedge clk); evt = '0;
    chk("R7 int_n event", {7'b0, int_n}, 8'h00);
    repeat (5) @(negedge clk);
    bus_read(1'b1, v); chk("R8 sticky", v, 8'h78);
    @(negedge clk); int_clr = 1'b1;
    @(negedge clk); int_clr = 1'b0;
    chk("R8 cleared pin", {7'b0, int_n}, 8'h01);
    bus_read(1'b1, v); chk("R8 cleared", v, 8'h70);
    @(negedge clk); evt = 5'b00001;
    @(negedge clk); evt = '0;
    bus_write(1'b1, 8'h00);
    chk("R7 masked", {7'b0, int_n}, 8'h01);
    bus_read(1'b1, v); chk("R7 masked status", v, 8'h68);
    @(negedge clk); int_clr = 1'b1;
    @(negedge clk); int_clr = 1'b0;

    // R9 escape gating
    esc_en = 1'b0;
    bus_write(1'b1, 8'h04);
    chk("R9 gated", {7'b0, esc_out}, 8'h00);
    bus_read(1'b1, v); chk("R9 status", v, 8'h64);
    @(negedge clk); esc_en = 1'b1;
    @(negedge clk); chk("R9 enabled", {7'b0, esc_out}, 8'h01);
    bus_write(1'b1, 8'h00);
    chk("R9 off", {7'b0, esc_out}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule